// File: doc/BRIEF.md
# Hardware Genetic Algorithm Engine

This block runs a complete genetic search loop in hardware. After a start pulse it seeds an internal pseudo-random generator and fills a population of binary chromosomes held in on-chip registers. It then presents every individual of the current generation on an output port, one per cycle, and waits for an external evaluator to return one fitness score per individual. Lower scores are better, and a score of zero is a perfect match.

Once all scores of a generation are in, the engine records the best individual. It then decides whether to stop. It stops when the best score is zero or when the generation count has reached a programmable limit. Otherwise it ranks the population with a sequential sort and builds the next generation in a second register bank. That generation holds an untouched copy of the best individual, and every other child is bred from two parents. Each parent is drawn by linear rank selection. The two parents are joined by single-point crossover, and each bit of the child is then flipped with a programmable probability. The evaluator and whatever circuit the chromosomes configure sit outside this block.

Top module: `ga_engine`

## Requirements
- R1: After reset, `done_o` is 0, `ind_valid_o` is 0 and `gen_o` is 0.
- R2: A start pulse loads the generator from `seed_i`, with a zero seed replaced by 1. The engine fills the population and then presents all 32 individuals on consecutive cycles with `ind_valid_o` high and `ind_idx_o` counting 0 to 31. The same seed, threshold and scores always give the same chromosome sequence.
- R3: Scores are taken only after the 32nd individual of a generation has been presented. They are taken one per `fit_valid_i` cycle and assigned to indices 0 to 31 in order. Strobes while individuals are being presented are ignored.
- R4: After the 32nd score, `best_o` and `best_fit_o` show the individual with the lowest score of that generation. When scores tie, the lower index wins.
- R5: Individual 0 of every bred generation is an unmodified copy of the previous generation's best individual, as defined in R4. No mutation is applied to it.
- R6: Parent choice depends only on the rank order of the scores. Any order-preserving change of the scores gives the same next generation.
- R7: Each child at index 1 to 31 takes bits below a cut point c from one parent and bits c and above from another parent of the previous generation, with 1 <= c <= 26.
- R8: A bit of a child is flipped when a fresh 8-bit random byte is below `mut_thr_i`. A threshold of 0 never flips, and 255 flips almost every bit.
- R9: When the best score of an evaluated generation is 0, `done_o` rises and `gen_o` equals the number of generations evaluated.
- R10: When `gen_o` reaches `gen_limit_i`, `done_o` rises; a limit of 0 acts as 1. `done_o` stays high until the next start pulse.
- R11: `gen_o` rises by exactly one after each fully scored generation and never otherwise changes except to 0 on start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a new search |
| seed_i | input | 32 | Generator seed, captured on start |
| mut_thr_i | input | 8 | Per-bit mutation threshold, captured on start |
| gen_limit_i | input | 16 | Maximum number of generations, captured on start |
| ind_valid_o | output | 1 | An individual is presented this cycle |
| ind_idx_o | output | 5 | Index of the presented individual |
| ind_data_o | output | 27 | Chromosome of the presented individual |
| fit_valid_i | input | 1 | A score is present on `fit_i` |
| fit_i | input | 16 | Score of the next individual, lower is better |
| best_o | output | 27 | Best chromosome of the last scored generation |
| best_fit_o | output | 16 | Score of `best_o` |
| gen_o | output | 16 | Number of generations scored so far |
| done_o | output | 1 | Search finished |

## Verification
The first run uses a score pattern with two equal minima and a stray zero-score strobe during presentation. This shows whether ties go to the lower index and whether early strobes leak into the score table. With the mutation threshold at 0, every child is searched against all parent pairs and cut points, which shows whether children come from single-point crossover alone. A rerun with the same seed and a scaled-but-ordered copy of the scores must reproduce the bred generation bit for bit, which shows whether selection depends on rank or on raw value. Further runs use a zero seed against seed 1, a threshold of 255, a planted zero score, and limits of 0 and 3. These separate seed substitution, mutation, the perfect-score stop and the generation-limit stop.

// File: rtl/ga_pkg.sv
// Shared types for the genetic algorithm engine.
// Assumes: nothing beyond IEEE 1800-2017.
package ga_pkg;

    // Top-level sequencing states of the engine.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_INIT,
        ST_EMIT,
        ST_COLLECT,
        ST_SORT,
        ST_ELITE,
        ST_SEL,
        ST_MUT,
        ST_DONE
    } ga_state_e;

    // Maximal-length feedback mask for a right-shifting 32-bit Galois register.
    localparam logic [31:0] GA_POLY32 = 32'h8020_0003;

endpackage

// File: rtl/ga_lfsr.sv
// Pseudo-random source: a Galois shift register that advances RW single
// steps per enabled cycle, so each enabled cycle yields a fresh RW-bit word.
// Assumes: POLY describes a maximal-length polynomial; a zero seed is
// replaced by 1 because the all-zero state would lock the register.
module ga_lfsr #(
    parameter int          RW   = 32,
    parameter logic [RW-1:0] POLY = ga_pkg::GA_POLY32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [RW-1:0] seed_i,
    input  logic          adv_i,
    output logic [RW-1:0] word_o
);

    logic [RW-1:0] state_q;

    // Apply RW single Galois steps to a state.
    function automatic logic [RW-1:0] jump(input logic [RW-1:0] s);
        logic [RW-1:0] t;
        t = s;
        for (int k = 0; k < RW; k++) begin
            t = t[0] ? ((t >> 1) ^ POLY) : (t >> 1);
        end
        return t;
    endfunction

    // Load the seed on start, otherwise advance when asked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= {{(RW-1){1'b0}}, 1'b1};
        end else if (load_i) begin
            state_q <= (seed_i == '0) ? {{(RW-1){1'b0}}, 1'b1} : seed_i;
        end else if (adv_i) begin
            state_q <= jump(state_q);
        end
    end

    assign word_o = state_q;

    // R2: the register never enters the locked all-zero state.
    p_lfsr_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

endmodule

// File: rtl/ga_rank_sort.sv
// Ranking unit: odd-even transposition sort of individual indices by their
// scores, lower score first, ties ordered by lower index. One pass per
// cycle, POP passes in total; done_o pulses for one cycle when finished.
// Assumes: POP is even and key_i is held stable from start_i to done_o.
module ga_rank_sort #(
    parameter int POP = 32,
    parameter int FW  = 16,
    localparam int IW = $clog2(POP),
    localparam int PW = $clog2(POP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [FW-1:0] key_i [POP],
    output logic [IW-1:0] ord_o [POP],
    output logic          done_o
);

    logic [PW-1:0] pass_q;
    logic          busy_q;
    logic [IW-1:0] ord_q [POP];
    logic          swap  [POP-1];

    // Decide for every adjacent pair whether it is out of order.
    for (genvar i = 0; i < POP - 1; i++) begin : g_cmp
        always_comb begin
            swap[i] = (key_i[ord_q[i+1]] < key_i[ord_q[i]]) ||
                      ((key_i[ord_q[i+1]] == key_i[ord_q[i]]) &&
                       (ord_q[i+1] < ord_q[i]));
        end
    end

    // Run the passes, alternating even and odd pair alignment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_o <= 1'b0;
            pass_q <= '0;
            for (int i = 0; i < POP; i++) ord_q[i] <= IW'(i);
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                busy_q <= 1'b1;
                pass_q <= '0;
                for (int i = 0; i < POP; i++) ord_q[i] <= IW'(i);
            end else if (busy_q) begin
                for (int i = 0; i < POP - 1; i++) begin
                    if (((i % 2) == 0) == (pass_q[0] == 1'b0) && swap[i]) begin
                        ord_q[i]   <= ord_q[i+1];
                        ord_q[i+1] <= ord_q[i];
                    end
                end
                pass_q <= pass_q + 1'b1;
                if (pass_q == PW'(POP - 1)) begin
                    busy_q <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assign ord_o = ord_q;

    // R6: at completion every adjacent rank pair is in non-decreasing score order.
    for (genvar i = 0; i < POP - 1; i++) begin : g_chk
        p_sorted_r6: assert property (@(posedge clk) disable iff (!rst_n)
            done_o |-> (key_i[ord_q[i]] <= key_i[ord_q[i+1]]));
    end

endmodule

// File: rtl/ga_mutator.sv
// Mutation slice: flips a group of LANES bits of a chromosome per call, one
// MW-bit random byte per bit, a bit flipping when its byte is below thr_i.
// The group is chosen by step_i; bits outside the group pass unchanged.
// Assumes: RW >= LANES * MW.
module ga_mutator #(
    parameter int CLEN = 27,
    parameter int RW   = 32,
    parameter int MW   = 8,
    localparam int LANES  = RW / MW,
    localparam int MSTEPS = (CLEN + LANES - 1) / LANES,
    localparam int SW     = (MSTEPS > 1) ? $clog2(MSTEPS) : 1
) (
    input  logic [CLEN-1:0] chrom_i,
    input  logic [SW-1:0]   step_i,
    input  logic [MW-1:0]   thr_i,
    input  logic [RW-1:0]   rnd_i,
    output logic [CLEN-1:0] chrom_o
);

    logic [CLEN-1:0] flip;

    // Per-bit flip decision from the byte lane assigned to that bit.
    for (genvar j = 0; j < CLEN; j++) begin : g_bit
        localparam int LANE = j % LANES;
        localparam int GRP  = j / LANES;
        assign flip[j] = (step_i == SW'(GRP)) &&
                         (rnd_i[LANE*MW +: MW] < thr_i);
    end

    assign chrom_o = chrom_i ^ flip;

    // R8: a zero threshold leaves the chromosome untouched.
    always_comb begin
        if (thr_i == '0) begin
            p_no_flip_r8: assert (chrom_o == chrom_i);
        end
    end

endmodule

// File: rtl/ga_engine.sv
// Genetic algorithm engine: holds two banks of POP chromosomes, presents the
// current bank, collects one score per individual (lower is better), ranks
// them, and breeds the next bank with elitism, linear rank selection,
// single-point crossover and per-bit mutation, until a zero score appears or
// the generation limit is reached.
// Assumes: POP is a power of two and even; 4*IW + CW <= RW; scores arrive
// in index order after the last individual has been presented.
module ga_engine #(
    parameter int POP  = 32,
    parameter int CLEN = 27,
    parameter int FW   = 16,
    parameter int GW   = 16,
    parameter int RW   = 32,
    parameter int MW   = 8,
    localparam int IW     = $clog2(POP),
    localparam int CW     = $clog2(CLEN),
    localparam int LANES  = RW / MW,
    localparam int MSTEPS = (CLEN + LANES - 1) / LANES,
    localparam int SW     = (MSTEPS > 1) ? $clog2(MSTEPS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [RW-1:0]   seed_i,
    input  logic [MW-1:0]   mut_thr_i,
    input  logic [GW-1:0]   gen_limit_i,
    output logic            ind_valid_o,
    output logic [IW-1:0]   ind_idx_o,
    output logic [CLEN-1:0] ind_data_o,
    input  logic            fit_valid_i,
    input  logic [FW-1:0]   fit_i,
    output logic [CLEN-1:0] best_o,
    output logic [FW-1:0]   best_fit_o,
    output logic [GW-1:0]   gen_o,
    output logic            done_o
);
    import ga_pkg::*;

    ga_state_e       state_q;
    logic [IW-1:0]   cnt_q;
    logic [IW-1:0]   child_q;
    logic [SW-1:0]   step_q;
    logic            cur_q;
    logic [GW-1:0]   gen_q;
    logic [GW-1:0]   lim_q;
    logic [MW-1:0]   thr_q;
    logic [IW-1:0]   best_idx_q;
    logic [FW-1:0]   best_fit_q;
    logic [CLEN-1:0] best_chrom_q;
    logic [CLEN-1:0] work_q;
    logic [FW-1:0]   fit_q [POP];
    logic [CLEN-1:0] pop_q [2][POP];

    logic [RW-1:0]   rnd;
    logic            lfsr_load, lfsr_adv;
    logic [IW-1:0]   ord [POP];
    logic            sort_start, sort_done;
    logic [CLEN-1:0] mut_out;

    // ---------------- random source ----------------
    assign lfsr_load = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
    assign lfsr_adv  = (state_q == ST_INIT) || (state_q == ST_SEL) ||
                       (state_q == ST_MUT);

    ga_lfsr #(.RW(RW), .POLY(RW'(GA_POLY32))) i_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (lfsr_load),
        .seed_i (seed_i),
        .adv_i  (lfsr_adv),
        .word_o (rnd)
    );

    // ---------------- score bookkeeping ----------------
    logic [FW-1:0] nb_fit;
    logic [GW-1:0] gen_nx;
    logic          last_fit, stop_now;

    // Best score including the one arriving now; decides the stop condition.
    always_comb begin
        nb_fit   = ((cnt_q == '0) || (fit_i < best_fit_q)) ? fit_i : best_fit_q;
        gen_nx   = gen_q + 1'b1;
        last_fit = (state_q == ST_COLLECT) && fit_valid_i && (cnt_q == IW'(POP - 1));
        stop_now = (nb_fit == '0) || (gen_nx >= lim_q);
    end

    assign sort_start = last_fit && !stop_now;

    ga_rank_sort #(.POP(POP), .FW(FW)) i_sort (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (sort_start),
        .key_i   (fit_q),
        .ord_o   (ord),
        .done_o  (sort_done)
    );

    // ---------------- selection and crossover ----------------
    logic [IW-1:0]   ra, rb, rc, rd, r1, r2;
    logic [CW-1:0]   cut;
    logic [CLEN-1:0] mask, par_a, par_b, xover;

    // Better of two uniform ranks gives a rank-linear choice; pick the cut.
    always_comb begin
        ra    = rnd[0*IW +: IW];
        rb    = rnd[1*IW +: IW];
        rc    = rnd[2*IW +: IW];
        rd    = rnd[3*IW +: IW];
        r1    = (ra < rb) ? ra : rb;
        r2    = (rc < rd) ? rc : rd;
        cut   = CW'(32'(rnd[4*IW +: CW]) % (CLEN - 1)) + 1'b1;
        par_a = pop_q[cur_q][ord[r1]];
        par_b = pop_q[cur_q][ord[r2]];
        for (int j = 0; j < CLEN; j++) mask[j] = (j < int'(cut));
        xover = (par_a & mask) | (par_b & ~mask);
    end

    ga_mutator #(.CLEN(CLEN), .RW(RW), .MW(MW)) i_mut (
        .chrom_i (work_q),
        .step_i  (step_q),
        .thr_i   (thr_q),
        .rnd_i   (rnd),
        .chrom_o (mut_out)
    );

    // ---------------- sequencer ----------------
    // Main state machine covering fill, present, score, rank and breed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            cnt_q        <= '0;
            child_q      <= '0;
            step_q       <= '0;
            cur_q        <= 1'b0;
            gen_q        <= '0;
            lim_q        <= GW'(1);
            thr_q        <= '0;
            best_idx_q   <= '0;
            best_fit_q   <= '0;
            best_chrom_q <= '0;
            work_q       <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start_i) begin
                        state_q <= ST_INIT;
                        cnt_q   <= '0;
                        cur_q   <= 1'b0;
                        gen_q   <= '0;
                        thr_q   <= mut_thr_i;
                        lim_q   <= (gen_limit_i == '0) ? GW'(1) : gen_limit_i;
                    end
                end
                ST_INIT: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == IW'(POP - 1)) state_q <= ST_EMIT;
                end
                ST_EMIT: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == IW'(POP - 1)) state_q <= ST_COLLECT;
                end
                ST_COLLECT: begin
                    if (fit_valid_i) begin
                        cnt_q <= cnt_q + 1'b1;
                        if ((cnt_q == '0) || (fit_i < best_fit_q)) begin
                            best_idx_q   <= cnt_q;
                            best_fit_q   <= fit_i;
                            best_chrom_q <= pop_q[cur_q][cnt_q];
                        end
                        if (last_fit) begin
                            gen_q   <= gen_nx;
                            state_q <= stop_now ? ST_DONE : ST_SORT;
                        end
                    end
                end
                ST_SORT: begin
                    if (sort_done) state_q <= ST_ELITE;
                end
                ST_ELITE: begin
                    child_q <= IW'(1);
                    state_q <= ST_SEL;
                end
                ST_SEL: begin
                    work_q  <= xover;
                    step_q  <= '0;
                    state_q <= ST_MUT;
                end
                ST_MUT: begin
                    work_q <= mut_out;
                    step_q <= step_q + 1'b1;
                    if (step_q == SW'(MSTEPS - 1)) begin
                        if (child_q == IW'(POP - 1)) begin
                            cur_q   <= ~cur_q;
                            cnt_q   <= '0;
                            state_q <= ST_EMIT;
                        end else begin
                            child_q <= child_q + 1'b1;
                            state_q <= ST_SEL;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Population banks: fill on start, elite and children into the idle bank.
    always_ff @(posedge clk) begin
        if (state_q == ST_INIT) begin
            pop_q[0][cnt_q] <= rnd[CLEN-1:0];
        end else if (state_q == ST_ELITE) begin
            pop_q[~cur_q][0] <= best_chrom_q;
        end else if (state_q == ST_MUT && step_q == SW'(MSTEPS - 1)) begin
            pop_q[~cur_q][child_q] <= mut_out;
        end
    end

    // Score table written in arrival order.
    always_ff @(posedge clk) begin
        if (state_q == ST_COLLECT && fit_valid_i) fit_q[cnt_q] <= fit_i;
    end

    assign ind_valid_o = (state_q == ST_EMIT);
    assign ind_idx_o   = cnt_q;
    assign ind_data_o  = pop_q[cur_q][cnt_q];
    assign best_o      = best_chrom_q;
    assign best_fit_o  = best_fit_q;
    assign gen_o       = gen_q;
    assign done_o      = (state_q == ST_DONE);

    // R5: the ranking unit's top entry is the individual tracked as best.
    p_elite_rank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ELITE) |-> (ord[0] == best_idx_q));

    // R2: presented indices step by one on consecutive valid cycles.
    p_emit_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_valid_o && $past(ind_valid_o)) |-> (ind_idx_o == IW'($past(ind_idx_o) + 1'b1)));

    // R11: the generation count only steps up by one or clears.
    p_gen_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_o != $past(gen_o)) |-> ((gen_o == GW'($past(gen_o) + 1'b1)) || (gen_o == '0)));

    // R9 and R10: finishing always has a perfect score or an exhausted limit behind it.
    p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ((best_fit_o == '0) || (gen_o >= lim_q)));

endmodule

// File: tb/test_ga_engine.sv
// Scoreboard bench for ga_engine: the driver queues the expected index order
// of each presentation, a monitor pops and compares it and captures the
// chromosomes; generation-level checks are computed from the requirements.
module test_ga_engine;
    localparam int POP  = 32;
    localparam int CLEN = 27;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [31:0]     seed_i = '0;
    logic [7:0]      mut_thr_i = '0;
    logic [15:0]     gen_limit_i = '0;
    logic            ind_valid_o;
    logic [4:0]      ind_idx_o;
    logic [CLEN-1:0] ind_data_o;
    logic            fit_valid_i = 1'b0;
    logic [15:0]     fit_i = '0;
    logic [CLEN-1:0] best_o;
    logic [15:0]     best_fit_o;
    logic [15:0]     gen_o;
    logic            done_o;

    ga_engine i_ga_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .seed_i(seed_i),
        .mut_thr_i(mut_thr_i), .gen_limit_i(gen_limit_i),
        .ind_valid_o(ind_valid_o), .ind_idx_o(ind_idx_o), .ind_data_o(ind_data_o),
        .fit_valid_i(fit_valid_i), .fit_i(fit_i), .best_o(best_o),
        .best_fit_o(best_fit_o), .gen_o(gen_o), .done_o(done_o)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int emit_cnt = 0;
    int cycles = 0;
    int exp_q[$];
    logic [CLEN-1:0] cap [POP];
    logic [CLEN-1:0] prv [POP];
    logic [CLEN-1:0] g0a [POP], g1a [POP], g1b [POP], g0c [POP], g0d [POP], g1d [POP];
    int fin [POP];

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare presented index with the queued expectation, capture data.
    always @(negedge clk) begin
        if (ind_valid_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected individual", 64'(ind_idx_o), 64'hff);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(int'(ind_idx_o) == e, "R2 index order", 64'(ind_idx_o), 64'(e));
            end
            cap[ind_idx_o] = ind_data_o;
            emit_cnt++;
        end
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic begin_gen();
        emit_cnt = 0;
        for (int i = 0; i < POP; i++) exp_q.push_back(i);
    endtask

    task automatic wait_emit();
        wait (emit_cnt == POP);
    endtask

    task automatic start_run(input logic [31:0] sd, input logic [7:0] th,
                             input logic [15:0] lim);
        seed_i = sd; mut_thr_i = th; gen_limit_i = lim;
        begin_gen();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic feed();
        @(negedge clk); @(negedge clk);
        for (int i = 0; i < POP; i++) begin
            fit_valid_i = 1'b1; fit_i = 16'(fin[i]);
            @(negedge clk);
        end
        fit_valid_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_done();
        for (int k = 0; k < 40 && !done_o; k++) @(negedge clk);
    endtask

    task automatic base_fit();
        for (int i = 0; i < POP; i++) fin[i] = ((i * 13) % 29) + 3;
        fin[9] = 1; fin[20] = 1;
    endtask

    // True when ch is a single-point crossover of two entries of prv.
    function automatic bit is_xover(input logic [CLEN-1:0] ch);
        for (int c = 1; c < CLEN; c++) begin
            logic [CLEN-1:0] m;
            m = (CLEN'(1) << c) - 1'b1;
            for (int a = 0; a < POP; a++) begin
                if ((prv[a] & m) == (ch & m)) begin
                    for (int b = 0; b < POP; b++) begin
                        if ((prv[b] & ~m) == (ch & ~m)) return 1'b1;
                    end
                end
            end
        end
        return 1'b0;
    endfunction

    initial begin
        int nx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(done_o == 1'b0, "R1 done after reset", 64'(done_o), 0);
        chk(ind_valid_o == 1'b0, "R1 valid after reset", 64'(ind_valid_o), 0);
        chk(gen_o == 16'd0, "R1 gen after reset", 64'(gen_o), 0);

        // ---- Run A: seed, no mutation, limit 2, stray strobes during presentation
        start_run(32'h1234_5678, 8'd0, 16'd2);
        wait (emit_cnt >= 4);
        fit_valid_i = 1'b1; fit_i = 16'd0;
        repeat (10) @(negedge clk);
        fit_valid_i = 1'b0;
        wait_emit();
        for (int i = 0; i < POP; i++) g0a[i] = cap[i];
        base_fit();
        begin_gen();
        feed();
        // R3: stray zero strobes ignored, so best score is 1 and search continues
        chk(best_fit_o == 16'd1, "R3 stray strobes ignored", 64'(best_fit_o), 1);
        chk(done_o == 1'b0, "R3 no early finish", 64'(done_o), 0);
        // R4: tie between 9 and 20 goes to 9
        chk(best_o == g0a[9], "R4 best tie to lower index", 64'(best_o), 64'(g0a[9]));
        chk(gen_o == 16'd1, "R11 gen after first scoring", 64'(gen_o), 1);
        wait_emit();
        for (int i = 0; i < POP; i++) g1a[i] = cap[i];
        chk(g1a[0] == g0a[9], "R5 elite copied", 64'(g1a[0]), 64'(g0a[9]));
        for (int i = 0; i < POP; i++) prv[i] = g0a[i];
        nx = 0;
        for (int i = 1; i < POP; i++) if (!is_xover(g1a[i])) nx++;
        chk(nx == 0, "R7 children are single-point crossovers", 64'(nx), 0);
        feed();
        wait_done();
        chk(done_o == 1'b1, "R10 limit reached", 64'(done_o), 1);
        chk(gen_o == 16'd2, "R10 gen at limit", 64'(gen_o), 2);

        // ---- Run B: same seed, scaled scores, planted zero
        start_run(32'h1234_5678, 8'd0, 16'd100);
        chk(done_o == 1'b0, "R10 start clears done", 64'(done_o), 0);
        wait_emit();
        nx = 0;
        for (int i = 0; i < POP; i++) if (cap[i] != g0a[i]) nx++;
        chk(nx == 0, "R2 same seed same population", 64'(nx), 0);
        base_fit();
        for (int i = 0; i < POP; i++) fin[i] = fin[i] * 3 + 1;
        begin_gen();
        feed();
        chk(best_fit_o == 16'd4, "R4 best scaled score", 64'(best_fit_o), 4);
        wait_emit();
        for (int i = 0; i < POP; i++) g1b[i] = cap[i];
        nx = 0;
        for (int i = 0; i < POP; i++) if (g1b[i] != g1a[i]) nx++;
        chk(nx == 0, "R6 rank-only selection", 64'(nx), 0);
        fin[4] = 0;
        feed();
        wait_done();
        chk(done_o == 1'b1, "R9 zero score finishes", 64'(done_o), 1);
        chk(gen_o == 16'd2, "R9 gen at zero score", 64'(gen_o), 2);
        chk(best_o == g1b[4], "R9 best is zero-score individual", 64'(best_o), 64'(g1b[4]));
        chk(best_fit_o == 16'd0, "R9 best score zero", 64'(best_fit_o), 0);

        // ---- Run C: seed 1, limit 0 acts as 1
        start_run(32'h0000_0001, 8'd255, 16'd0);
        wait_emit();
        for (int i = 0; i < POP; i++) g0c[i] = cap[i];
        base_fit();
        feed();
        wait_done();
        chk(done_o == 1'b1, "R10 zero limit acts as one", 64'(done_o), 1);
        chk(gen_o == 16'd1, "R10 gen with zero limit", 64'(gen_o), 1);

        // ---- Run D: zero seed, full mutation, limit 3
        start_run(32'h0000_0000, 8'd255, 16'd3);
        wait_emit();
        for (int i = 0; i < POP; i++) g0d[i] = cap[i];
        nx = 0;
        for (int i = 0; i < POP; i++) if (g0d[i] != g0c[i]) nx++;
        chk(nx == 0, "R2 zero seed replaced by one", 64'(nx), 0);
        begin_gen();
        feed();
        chk(gen_o == 16'd1 && !done_o, "R11 gen one of three", 64'(gen_o), 1);
        wait_emit();
        for (int i = 0; i < POP; i++) g1d[i] = cap[i];
        chk(g1d[0] == g0d[9], "R5 elite not mutated", 64'(g1d[0]), 64'(g0d[9]));
        for (int i = 0; i < POP; i++) prv[i] = g0d[i];
        nx = 0;
        for (int i = 1; i < POP; i++) if (!is_xover(g1d[i])) nx++;
        chk(nx >= 25, "R8 high threshold mutates", 64'(nx), 25);
        begin_gen();
        feed();
        chk(gen_o == 16'd2 && !done_o, "R11 gen two of three", 64'(gen_o), 2);
        wait_emit();
        feed();
        wait_done();
        chk(done_o == 1'b1, "R10 finish at three", 64'(done_o), 1);
        chk(gen_o == 16'd3, "R11 gen three", 64'(gen_o), 3);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule